// File: doc/BRIEF.md
# Dual-Register Input Capture Timer Channel

This block is a free-running up-counter with two capture registers. Each register takes a copy of the count on a chosen transition of input line A, and the two registers load in a fixed alternating order. The channel suits pulse-width, period and phase measurement. A small register bus programs the edge choices, the compare value and the interrupt mask. The same bus reads back the captured values, the live count and a sticky status word.

Four sources reset the counter to zero and restart the alternation at register A: a synchronous pulse input, a software command, a match against the compare register, and an external edge taken from line A or line B. Both input lines pass through a two-flop synchronizer and an edge detector before they are used. The A/B alternation is a two-state machine. In state `SEQ_WAIT_A`, an edge that the A-select field accepts loads register A and moves to `SEQ_WAIT_B`. In `SEQ_WAIT_B`, an edge that the B-select field accepts loads register B and moves back to `SEQ_WAIT_A`. Any trigger forces `SEQ_WAIT_A`.

Bus map: 0 mode (read/write), 1 command (write only), 2 compare value (read/write), 3 capture A (read), 4 capture B (read), 5 status (read, clears), 6 interrupt mask (read/write), 7 count (read). The read data is combinational while `bus_rd` is high. Side effects of a read take place at the clock edge.

Top module: `dual_capture_timer`

## Requirements
- R1: After reset the count is 0, status is 0, both capture registers are 0, mode is 0, the interrupt mask is 0, the compare value is 0xFFFF and irq is low.
- R2: With no trigger, the count rises by one on every clock, and address 7 reads the current count.
- R3: A change on line A reaches the edge detector two clocks after it is sampled. A load stores the count value that is present in the cycle the detected edge pulse is seen.
- R4: Mode bits [1:0] select the line-A edge that loads register A, and mode bits [3:2] select the line-A edge that loads register B. The encoding is 0 none, 1 rising, 2 falling, 3 both.
- R5: Loads alternate as A, B, A, B. While waiting for B, an edge that only the A field accepts loads nothing.
- R6: A load into a register whose previous value has not been read overwrites the value and sets status bit 2 (load overrun).
- R7: A trigger (sync_in high, a write of 1 to bit 0 at address 1, an enabled compare match, or an external trigger) makes the count 0 on the next clock and returns the alternation to register A. A trigger takes priority over a capture in the same cycle.
- R8: Mode bit 6 picks the external trigger source (0 line A, 1 line B). Mode bits [5:4] pick its edge (0 none, which disables it, 1 rising, 2 falling, 3 both). A detected external edge sets status bit 5.
- R9: When the count equals the compare value (address 2), status bit 0 is set. The match acts as a trigger only while mode bit 8 is 1.
- R10: At count 0xFFFF with no trigger, the count wraps to 0 and status bit 1 (overflow) is set.
- R11: Status bits 0 compare, 1 overflow, 2 overrun, 3 A loaded, 4 B loaded and 5 external are sticky. A read at address 5 clears them, but an event in the same cycle as the read stays set.
- R12: irq is high exactly when some status bit is set whose bit at address 6 is also set.
- R13: While mode bit 7 (waveform select) is 1, no capture load and no external trigger occurs.
- R14: Reading address 3 or address 4 marks that register as read, so its next load does not set the overrun bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_rd is high |
| line_a | input | 1 | Capture and trigger input A (asynchronous) |
| line_b | input | 1 | Trigger input B (asynchronous) |
| sync_in | input | 1 | Synchronous counter reset pulse |
| irq | output | 1 | Masked OR of status bits |

## Verification
A wrong alternation state shows up at the next accepted edge. The wrong capture register changes, or no register changes, and the A-loaded and B-loaded status bits disagree on the following status read. A lost trigger or a wrong counter step shows up as a count off by one or more on the next read of address 7, and every later captured value is shifted by the same amount. An unread flag that is cleared at the wrong time shows up as a missing or spurious overrun bit on the status read after the second load. The irq pin is compared on every clock, so a status bit that is set or cleared a cycle off is seen within one clock.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_sel_t;

    typedef enum logic [0:0] {
        SEQ_WAIT_A = 1'b0,
        SEQ_WAIT_B = 1'b1
    } seq_state_t;

    // bus addresses
    localparam int ADR_MODE   = 0;
    localparam int ADR_CMD    = 1;
    localparam int ADR_CMPV   = 2;
    localparam int ADR_CAP_A  = 3;
    localparam int ADR_CAP_B  = 4;
    localparam int ADR_STATUS = 5;
    localparam int ADR_MASK   = 6;
    localparam int ADR_COUNT  = 7;

    // mode word layout
    localparam int MODE_W     = 9;
    localparam int M_LDA_LO   = 0;
    localparam int M_LDB_LO   = 2;
    localparam int M_EXT_LO   = 4;
    localparam int M_EXT_SRC  = 6;
    localparam int M_WAVE     = 7;
    localparam int M_CMP_TRIG = 8;

    // status word layout
    localparam int ST_W   = 6;
    localparam int ST_CMP = 0;
    localparam int ST_OVF = 1;
    localparam int ST_OVR = 2;
    localparam int ST_LDA = 3;
    localparam int ST_LDB = 4;
    localparam int ST_EXT = 5;

    function automatic logic edge_hit(edge_sel_t sel, logic rise, logic fall);
        logic hit;
        unique case (sel)
            EDGE_NONE: hit = 1'b0;
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_BOTH: hit = rise | fall;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/cap_edge_sync.sv
module cap_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    // STAGES flops synchronize, one more holds the previous value
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], din};
    end

    assign rise =  chain[STAGES-1] & ~chain[STAGES];
    assign fall = ~chain[STAGES-1] &  chain[STAGES];
endmodule

// File: rtl/cap_counter.sv
module cap_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sync_pulse,
    input  logic         sw_pulse,
    input  logic         ext_pulse,
    input  logic         cmp_trig_en,
    input  logic [W-1:0] cmp_val,
    output logic [W-1:0] count,
    output logic         trig,
    output logic         cmp_evt,
    output logic         ovf_evt
);
    always_comb begin
        cmp_evt = (count == cmp_val);
        trig    = sync_pulse | sw_pulse | ext_pulse | (cmp_trig_en & cmp_evt);
        ovf_evt = (&count) & ~trig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    count <= '0;
        else if (trig) count <= '0;
        else           count <= count + 1'b1;
    end
endmodule

// File: rtl/cap_seq.sv
module cap_seq
    import cap_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         trig,
    input  logic         cap_enable,
    input  logic         hit_a,
    input  logic         hit_b,
    input  logic         rd_a,
    input  logic         rd_b,
    input  logic [W-1:0] count,
    output logic [W-1:0] cap_a,
    output logic [W-1:0] cap_b,
    output logic         lda_evt,
    output logic         ldb_evt,
    output logic         ovr_evt
);
    seq_state_t state, state_nxt;
    logic       unread_a, unread_b;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_WAIT_A;
        else        state <= state_nxt;
    end

    // next state and load strobes
    always_comb begin
        state_nxt = state;
        lda_evt   = 1'b0;
        ldb_evt   = 1'b0;
        if (trig) begin
            state_nxt = SEQ_WAIT_A;
        end else if (cap_enable) begin
            unique case (state)
                SEQ_WAIT_A: if (hit_a) begin
                    lda_evt   = 1'b1;
                    state_nxt = SEQ_WAIT_B;
                end
                SEQ_WAIT_B: if (hit_b) begin
                    ldb_evt   = 1'b1;
                    state_nxt = SEQ_WAIT_A;
                end
                default: state_nxt = SEQ_WAIT_A;
            endcase
        end
        ovr_evt = (lda_evt & unread_a & ~rd_a) | (ldb_evt & unread_b & ~rd_b);
    end

    // capture storage and unread tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_a    <= '0;
            cap_b    <= '0;
            unread_a <= 1'b0;
            unread_b <= 1'b0;
        end else begin
            if (lda_evt) begin
                cap_a    <= count;
                unread_a <= 1'b1;
            end else if (rd_a) begin
                unread_a <= 1'b0;
            end
            if (ldb_evt) begin
                cap_b    <= count;
                unread_b <= 1'b1;
            end else if (rd_b) begin
                unread_b <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dual_capture_timer.sv
module dual_capture_timer
    import cap_timer_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              line_a,
    input  logic              line_b,
    input  logic              sync_in,
    output logic              irq
);
    localparam logic [CNT_W-1:0] CMP_RST = '1;

    logic [MODE_W-1:0] mode_q;
    logic [CNT_W-1:0]  cmp_q;
    logic [ST_W-1:0]   mask_q;
    logic [ST_W-1:0]   st_q;
    logic [ST_W-1:0]   st_evt;

    logic a_rise, a_fall, b_rise, b_fall;
    logic wave_mode, ext_rise, ext_fall, ext_pulse, sw_pulse;
    logic hit_a, hit_b, rd_a, rd_b, rd_status;
    logic trig, cmp_evt, ovf_evt, lda_evt, ldb_evt, ovr_evt;
    logic [CNT_W-1:0] count, cap_a, cap_b;

    function automatic logic at(logic [ADDR_W-1:0] a, int reg_idx);
        return a == ADDR_W'(reg_idx);
    endfunction

    cap_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
        .clk(clk), .rst_n(rst_n), .din(line_a), .rise(a_rise), .fall(a_fall)
    );
    cap_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
        .clk(clk), .rst_n(rst_n), .din(line_b), .rise(b_rise), .fall(b_fall)
    );

    always_comb begin
        wave_mode = mode_q[M_WAVE];
        ext_rise  = mode_q[M_EXT_SRC] ? b_rise : a_rise;
        ext_fall  = mode_q[M_EXT_SRC] ? b_fall : a_fall;
        ext_pulse = ~wave_mode &
                    edge_hit(edge_sel_t'(mode_q[M_EXT_LO +: 2]), ext_rise, ext_fall);
        hit_a     = edge_hit(edge_sel_t'(mode_q[M_LDA_LO +: 2]), a_rise, a_fall);
        hit_b     = edge_hit(edge_sel_t'(mode_q[M_LDB_LO +: 2]), a_rise, a_fall);
        sw_pulse  = bus_wr & at(bus_addr, ADR_CMD) & bus_wdata[0];
        rd_a      = bus_rd & at(bus_addr, ADR_CAP_A);
        rd_b      = bus_rd & at(bus_addr, ADR_CAP_B);
        rd_status = bus_rd & at(bus_addr, ADR_STATUS);
    end

    cap_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .sync_pulse(sync_in), .sw_pulse(sw_pulse), .ext_pulse(ext_pulse),
        .cmp_trig_en(mode_q[M_CMP_TRIG]), .cmp_val(cmp_q),
        .count(count), .trig(trig), .cmp_evt(cmp_evt), .ovf_evt(ovf_evt)
    );

    cap_seq #(.W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .trig(trig), .cap_enable(~wave_mode),
        .hit_a(hit_a), .hit_b(hit_b), .rd_a(rd_a), .rd_b(rd_b), .count(count),
        .cap_a(cap_a), .cap_b(cap_b),
        .lda_evt(lda_evt), .ldb_evt(ldb_evt), .ovr_evt(ovr_evt)
    );

    always_comb begin
        st_evt          = '0;
        st_evt[ST_CMP]  = cmp_evt;
        st_evt[ST_OVF]  = ovf_evt;
        st_evt[ST_OVR]  = ovr_evt;
        st_evt[ST_LDA]  = lda_evt;
        st_evt[ST_LDB]  = ldb_evt;
        st_evt[ST_EXT]  = ext_pulse;
    end

    // configuration registers and sticky status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            cmp_q  <= CMP_RST;
            mask_q <= '0;
            st_q   <= '0;
        end else begin
            if (bus_wr && at(bus_addr, ADR_MODE)) mode_q <= bus_wdata[MODE_W-1:0];
            if (bus_wr && at(bus_addr, ADR_CMPV)) cmp_q  <= bus_wdata;
            if (bus_wr && at(bus_addr, ADR_MASK)) mask_q <= bus_wdata[ST_W-1:0];
            st_q <= (rd_status ? '0 : st_q) | st_evt;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if      (at(bus_addr, ADR_MODE))   bus_rdata = CNT_W'(mode_q);
            else if (at(bus_addr, ADR_CMPV))   bus_rdata = cmp_q;
            else if (at(bus_addr, ADR_CAP_A))  bus_rdata = cap_a;
            else if (at(bus_addr, ADR_CAP_B))  bus_rdata = cap_b;
            else if (at(bus_addr, ADR_STATUS)) bus_rdata = CNT_W'(st_q);
            else if (at(bus_addr, ADR_MASK))   bus_rdata = CNT_W'(mask_q);
            else if (at(bus_addr, ADR_COUNT))  bus_rdata = count;
        end
    end

    assign irq = |(st_q & mask_q);
endmodule

// File: rtl/dual_capture_timer_chk.sv
module dual_capture_timer_chk #(
    parameter int CNT_W = 16,
    parameter int ST_W  = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig,
    input logic [CNT_W-1:0] count,
    input logic             lda_evt,
    input logic             ldb_evt,
    input logic [CNT_W-1:0] cap_a,
    input logic [CNT_W-1:0] cap_b,
    input logic             wave_mode,
    input logic             rd_status,
    input logic [ST_W-1:0]  st_q,
    input logic [ST_W-1:0]  st_evt
);
    p_trig_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (count == '0));

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && !(&count)) |=> ((count - $past(count)) == CNT_W'(1)));

    p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && (&count)) |=> ((count == '0) && st_q[1]));

    p_cap_a_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lda_evt |=> (cap_a == $past(count)));

    p_cap_b_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ldb_evt |=> (cap_b == $past(count)));

    p_one_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lda_evt, ldb_evt}));

    p_wave_blocks_r13: assert property (@(posedge clk) disable iff (!rst_n)
        wave_mode |-> (!lda_evt && !ldb_evt));

    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && (st_evt == '0)) |=> (st_q == '0));

    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_status |=> ((st_q & $past(st_q)) == $past(st_q)));
endmodule

bind dual_capture_timer dual_capture_timer_chk #(.CNT_W(CNT_W), .ST_W(6)) u_chk (
    .clk(clk), .rst_n(rst_n), .trig(trig), .count(count),
    .lda_evt(lda_evt), .ldb_evt(ldb_evt), .cap_a(cap_a), .cap_b(cap_b),
    .wave_mode(wave_mode), .rd_status(rd_status), .st_q(st_q), .st_evt(st_evt)
);

// File: tb/dual_capture_timer_test.sv
`timescale 1ns/1ps
module dual_capture_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        line_a = 1'b0, line_b = 1'b0, sync_in = 1'b0;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dual_capture_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .line_a(line_a), .line_b(line_b), .sync_in(sync_in), .irq(irq)
    );

    // ---------------- behavioural reference ----------------
    bit [15:0] m_cnt, m_c, m_ra, m_rb;
    bit [8:0]  m_mode;
    bit [5:0]  m_st, m_mask;
    bit        m_wantb, m_ua, m_ub;
    bit        ma1, ma2, ma3, mb1, mb2, mb3;

    function automatic bit mhit(bit [1:0] s, bit r, bit f);
        return (s == 2'd1 && r) || (s == 2'd2 && f) || (s == 2'd3 && (r || f));
    endfunction

    function automatic bit [15:0] mread(bit [2:0] a);
        case (a)
            3'd0: return {7'b0, m_mode};
            3'd2: return m_c;
            3'd3: return m_ra;
            3'd4: return m_rb;
            3'd5: return {10'b0, m_st};
            3'd6: return {10'b0, m_mask};
            3'd7: return m_cnt;
            default: return 16'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_c = 16'hFFFF; m_ra = 0; m_rb = 0; m_mode = 0;
            m_st = 0; m_mask = 0; m_wantb = 0; m_ua = 0; m_ub = 0;
            ma1 = 0; ma2 = 0; ma3 = 0; mb1 = 0; mb2 = 0; mb3 = 0;
        end else begin
            bit ar, af, br, bf, wave, ext, cmp, sw, trig, ovf, la, lb, rda, rdb, rds, ovr;
            ar = ma2 && !ma3;  af = !ma2 && ma3;
            br = mb2 && !mb3;  bf = !mb2 && mb3;
            wave = m_mode[7];
            ext  = !wave && mhit(m_mode[5:4], m_mode[6] ? br : ar, m_mode[6] ? bf : af);
            cmp  = (m_cnt == m_c);
            sw   = bus_wr && bus_addr == 3'd1 && bus_wdata[0];
            trig = sync_in || sw || ext || (m_mode[8] && cmp);
            ovf  = (m_cnt == 16'hFFFF) && !trig;
            la = 0; lb = 0;
            if (!trig && !wave) begin
                if (!m_wantb && mhit(m_mode[1:0], ar, af)) la = 1;
                else if (m_wantb && mhit(m_mode[3:2], ar, af)) lb = 1;
            end
            rda = bus_rd && bus_addr == 3'd3;
            rdb = bus_rd && bus_addr == 3'd4;
            rds = bus_rd && bus_addr == 3'd5;
            ovr = (la && m_ua && !rda) || (lb && m_ub && !rdb);
            if (la) begin m_ra = m_cnt; m_ua = 1; m_wantb = 1; end
            else if (rda) m_ua = 0;
            if (lb) begin m_rb = m_cnt; m_ub = 1; m_wantb = 0; end
            else if (rdb) m_ub = 0;
            if (trig) m_wantb = 0;
            m_st  = (rds ? 6'd0 : m_st) | {ext, lb, la, ovr, ovf, cmp};
            m_cnt = trig ? 16'd0 : m_cnt + 16'd1;
            if (bus_wr && bus_addr == 3'd0) m_mode = bus_wdata[8:0];
            if (bus_wr && bus_addr == 3'd2) m_c    = bus_wdata;
            if (bus_wr && bus_addr == 3'd6) m_mask = bus_wdata[5:0];
            ma3 = ma2; ma2 = ma1; ma1 = line_a;
            mb3 = mb2; mb2 = mb1; mb1 = line_b;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // irq against the reference on every clock (R12)
    always @(negedge clk) begin
        if (rst_n && !done) chk("R12 irq per-cycle", int'(irq), int'(|(m_st & m_mask)));
    end

    task automatic wr(bit [2:0] a, bit [15:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 0;
    endtask

    task automatic rd(bit [2:0] a, string req, output bit [15:0] v);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        #1;
        v = bus_rdata;
        chk(req, int'(v), int'(mread(a)));
        @(posedge clk); #1;
        bus_rd = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_a();
        @(negedge clk); line_a = 1;
        idle(4);
        line_a = 0;
        idle(4);
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=finish", cycles);
            finish_run();
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        bit [15:0] v, v1;
        idle(3);
        rst_n = 1;

        // R1 reset values
        rd(3'd5, "R1 status", v);  chk("R1 status zero", int'(v), 0);
        rd(3'd3, "R1 capA", v);    chk("R1 capA zero", int'(v), 0);
        rd(3'd0, "R1 mode", v);    chk("R1 mode zero", int'(v), 0);
        rd(3'd2, "R1 cmp", v);     chk("R1 cmp ffff", int'(v), 16'hFFFF);
        chk("R1 irq low", int'(irq), 0);

        // R2 / R7 software trigger and counting
        wr(3'd1, 16'h1);
        rd(3'd7, "R7 count after sw trig", v); chk("R7 count zero", int'(v), 0);
        idle(3);
        rd(3'd7, "R2 count", v); chk("R2 count steps", int'(v), 4);

        // R3 / R4 capture A on rising, B on falling
        wr(3'd0, 16'h0009);
        wr(3'd1, 16'h1);
        @(negedge clk); line_a = 1; idle(5);
        line_a = 0; idle(5);
        rd(3'd3, "R3 capA", v); chk("R3 capA value", int'(v), 2);
        rd(3'd4, "R4 capB falling", v);
        rd(3'd5, "R4 status", v);
        chk("R4 A loaded", int'(v[3]), 1);
        chk("R4 B loaded", int'(v[4]), 1);

        // R5 ordering: B field none, second A edge loads nothing
        wr(3'd0, 16'h0001);
        wr(3'd1, 16'h1);
        pulse_a();
        rd(3'd3, "R5 capA first", v1);
        rd(3'd5, "R5 clear", v);
        pulse_a();
        rd(3'd3, "R5 capA kept", v); chk("R5 capA unchanged", int'(v), int'(v1));
        rd(3'd5, "R5 status", v);    chk("R5 no A load", int'(v[3]), 0);

        // R6 overrun, R14 read clears pending
        wr(3'd0, 16'h0005);
        wr(3'd1, 16'h1);
        rd(3'd5, "R6 clear", v);
        pulse_a(); pulse_a(); pulse_a();
        rd(3'd5, "R6 status", v);    chk("R6 overrun set", int'(v[2]), 1);
        rd(3'd3, "R14 read A", v);
        rd(3'd4, "R14 read B", v);
        rd(3'd5, "R14 clear", v);
        pulse_a(); pulse_a();
        rd(3'd5, "R14 status", v);   chk("R14 no overrun", int'(v[2]), 0);

        // R7 sync input resets count and sequence
        @(negedge clk); sync_in = 1; @(posedge clk); #1; sync_in = 0;
        rd(3'd7, "R7 sync count", v); chk("R7 sync zero", int'(v), 0);
        rd(3'd5, "R7 clear", v);
        pulse_a();
        rd(3'd5, "R7 seq", v);
        chk("R7 seq back to A", int'(v[3]), 1);
        chk("R7 no B load", int'(v[4]), 0);

        // R9 compare trigger
        wr(3'd2, 16'd20);
        wr(3'd0, 16'h0105);
        wr(3'd1, 16'h1);
        idle(30);
        rd(3'd7, "R9 count bounded", v);
        rd(3'd5, "R9 status", v);  chk("R9 compare seen", int'(v[0]), 1);
        wr(3'd0, 16'h0005);
        wr(3'd2, 16'hFFFF);

        // R8 external trigger from B falling
        wr(3'd0, 16'h0065);
        @(negedge clk); line_b = 1; idle(5);
        rd(3'd5, "R8 clear", v);
        @(negedge clk); line_b = 0; idle(2);
        rd(3'd7, "R8 count", v);   chk("R8 ext reset", int'(v), 0);
        rd(3'd5, "R8 status", v);  chk("R8 ext bit", int'(v[5]), 1);

        // R8 edge none disables
        wr(3'd0, 16'h0045);
        rd(3'd5, "R8 clear2", v);
        @(negedge clk); line_b = 1; idle(5);
        line_b = 0; idle(5);
        rd(3'd5, "R8 none", v);    chk("R8 disabled", int'(v[5]), 0);

        // R13 waveform select blocks loads and external trigger
        wr(3'd0, 16'h0095);
        wr(3'd1, 16'h1);
        rd(3'd5, "R13 clear", v);
        pulse_a();
        rd(3'd5, "R13 status", v);
        chk("R13 no load", int'(v[3]), 0);
        chk("R13 no ext", int'(v[5]), 0);

        // R12 interrupt mask
        wr(3'd0, 16'h0005);
        wr(3'd6, 16'h0008);
        wr(3'd1, 16'h1);
        rd(3'd5, "R12 clear", v);
        pulse_a();
        chk("R12 irq high", int'(irq), 1);
        rd(3'd5, "R12 read", v);
        idle(1);
        chk("R12 irq low", int'(irq), 0);
        wr(3'd6, 16'h0000);

        // R10 overflow
        wr(3'd1, 16'h1);
        rd(3'd5, "R10 clear", v);
        idle(65540);
        rd(3'd5, "R10 status", v);
        chk("R10 overflow", int'(v[1]), 1);
        rd(3'd7, "R10 count", v);

        // R11 event during status read survives
        wr(3'd2, 16'h0000);
        wr(3'd1, 16'h1);
        rd(3'd5, "R11 read with event", v);
        rd(3'd5, "R11 second read", v);
        chk("R11 concurrent event kept", int'(v[0]), 1);

        idle(2);
        finish_run();
    end
endmodule